// File: doc/BRIEF.md
# BCD Calendar Clock with Per-Field Alarms

This block keeps wall-clock time as six BCD counters (second, minute, hour, day, month and two-digit year). A programmable prescaler divides the system clock into a one-second tick. The seconds field counts on every tick, and each higher field counts when the field below it wraps. The day field wraps at the length of the current month, and February has 29 days when the year is divisible by four.

Each field has its own BCD alarm value, interrupt enable, sticky match flag and write-one-to-clear bit. A single registered interrupt line reports any flag whose enable is set. A byte-wide register bus reads and writes every register. A control register holds the whole calendar in its reset state, and it can put any field above seconds into a test mode in which that field counts on every tick. This lets software check rollovers quickly.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset: second, minute, hour and year read 0x00; day and month read 0x01; each alarm holds its field's minimum; control reads 0x80; divisor reads DIV_RESET (99); enable and flag registers read 0x00; irq is 0.
- R2: Address map: 0..5 = counters (0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year), 6 = control, 7 = divisor, 8..13 = alarms in the same field order, 14 = interrupt enable, 15 = flags on read and clear on write. bus_rdata shows the register addressed in the previous cycle.
- R3: Control bit 7 = 1 holds every counter at its reset value and stops the prescaler. While it is set, counter writes are ignored.
- R4: With divisor D, a tick occurs once every D+1 clocks after release. Second steps on each tick. A field with test mode off steps only when the field below it steps and wraps. Counters never change without a tick, a write or hold.
- R5: Second and minute wrap from 0x59 to 0x00. Hour wraps from 0x23 to 0x00. Month wraps from 0x12 to 0x01. Year wraps from 0x99 to 0x00.
- R6: Day wraps to 0x01 after 0x31, 0x30 or 0x28/0x29, depending on the current month. February has 29 days when the BCD year is divisible by 4. Months 04, 06, 09 and 11 have 30 days.
- R7: Control bits 1..5 put minute, hour, day, month and year (in that order) into test mode. A field in test mode steps on every tick and still carries into the next field when it wraps.
- R8: A write of a value that is not BCD or is outside the field's range (day 01..31, month 01..12) stores the field's minimum. Counters always hold legal BCD.
- R9: Enable, flag and clear registers use bit 0 = second up to bit 5 = year. A field's flag sets on the tick that steps its counter onto the alarm value, and it then stays set until cleared.
- R10: Writing 1 to a clear bit clears that flag. Writing 0 leaves the flag unchanged. A set in the same cycle wins over a clear.
- R11: irq equals the OR of (flags AND enables), registered, one clock after the flags.
- R12: Reserved bits read as zero: control bits 0 and 6, and bits 6 and 7 of enable and flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Alarm interrupt request |

## Verification
The assertions assume that bus writes are single-cycle strobes with a valid address. They also assume the divisor is changed only while the calendar is held, so that the tick spacing they reason about is stable. The stimulus writes the divisor only while the calendar is held. It times every counter write and read inside a window well clear of the next tick, so no write ever races a carry. Checks that depend on the tick count are sampled in the middle of a tick period, which keeps the expected values independent of small phase offsets.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NF     = 6;
  localparam int DIV_W  = 8;
  localparam int IDX_DAY  = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;
  localparam logic [3:0] A_CTRL = 4'd6;
  localparam logic [3:0] A_DIV  = 4'd7;
  localparam int         A_ALM  = 8;
  localparam logic [3:0] A_EN   = 4'd14;
  localparam logic [3:0] A_FLAG = 4'd15;

  function automatic logic [7:0] f_min(input int f);
    return (f == IDX_DAY || f == IDX_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] f_max(input int f);
    case (f)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return 8'h31;
      4:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic bcd_legal(input logic [7:0] v, input logic [7:0] lo,
                                     input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10 = 2 (mod 4), so a BCD year divides by 4 when lo + 2*hi does
  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    logic [4:0] r;
    r = {1'b0, yr[3:0]} + {yr[7:4], 1'b0};
    case (mon)
      8'h02:                      return (r[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] divisor,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt >= divisor);
      cnt  <= (cnt >= divisor) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field import rtc_pkg::*; #(
  parameter logic [7:0] MIN_V = 8'h00,
  parameter logic [7:0] MAX_V = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       adv,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic [7:0] limit,
  output logic [7:0] value,
  output logic       wrap,
  output logic [7:0] next_v
);
  assign wrap   = (value >= limit);
  assign next_v = wrap ? MIN_V : bcd_inc(value);

  always_ff @(posedge clk) begin
    if (rst || hold)  value <= MIN_V;
    else if (wr_en)   value <= bcd_legal(wdata, MIN_V, MAX_V) ? wdata : MIN_V;
    else if (adv)     value <= next_v;
  end
endmodule

// File: rtl/rtc_alarm_bank.sv
module rtc_alarm_bank import rtc_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic [NF-1:0]      alm_wr,
  input  logic [7:0]         wdata,
  input  logic               en_wr,
  input  logic [NF-1:0]      clr,
  input  logic [NF-1:0]      adv,
  input  logic [NF-1:0][7:0] next_v,
  output logic [NF-1:0][7:0] alarm,
  output logic [NF-1:0]      en,
  output logic [NF-1:0]      flags,
  output logic               irq
);
  logic [NF-1:0] hit;

  always_comb begin
    for (int i = 0; i < NF; i++) hit[i] = adv[i] && (next_v[i] == alarm[i]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NF; i++) begin
      if (rst)            alarm[i] <= f_min(i);
      else if (alm_wr[i]) alarm[i] <= bcd_legal(wdata, f_min(i), f_max(i)) ? wdata : f_min(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      if (en_wr) en <= wdata[NF-1:0];
      flags <= (flags & ~clr) | hit;
      irq   <= |(flags & en);
    end
  end
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc import rtc_pkg::*; #(
  parameter logic [DIV_W-1:0] DIV_RESET = 8'd99
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic               hold_q;
  logic [5:1]         test_q;
  logic [DIV_W-1:0]   div_q;
  logic               tick;
  logic [NF-1:0]      test_v, cnt_wr, alm_wr, adv, wrap, irq_en, flags, clr_v;
  logic [NF-1:0][7:0] cnt, lim, next_v, alarm;
  logic               en_wr;
  logic [7:0]         rd_mux;

  assign test_v = {test_q, 1'b0};

  // bus write decode
  always_comb begin
    for (int i = 0; i < NF; i++) begin
      cnt_wr[i] = bus_wr && (bus_addr == 4'(i));
      alm_wr[i] = bus_wr && (bus_addr == 4'(A_ALM + i));
    end
    en_wr = bus_wr && (bus_addr == A_EN);
    clr_v = (bus_wr && (bus_addr == A_FLAG)) ? bus_wdata[NF-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      test_q <= '0;
      div_q  <= DIV_RESET;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        hold_q <= bus_wdata[7];
        test_q <= bus_wdata[5:1];
      end
      if (bus_addr == A_DIV) div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  rtc_tick_gen #(.W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .hold(hold_q), .divisor(div_q), .tick(tick)
  );

  // carry chain: each field steps on a carry or, in test mode, on every tick
  always_comb begin
    logic carry;
    carry = tick;
    for (int i = 0; i < NF; i++) begin
      adv[i] = (carry || (tick && test_v[i])) && !cnt_wr[i] && !hold_q;
      carry  = adv[i] && wrap[i];
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    if (i == IDX_DAY) begin : g_lim_day
      assign lim[i] = month_days(cnt[IDX_MON], cnt[IDX_YEAR]);
    end else begin : g_lim_fix
      assign lim[i] = f_max(i);
    end
    rtc_bcd_field #(.MIN_V(f_min(i)), .MAX_V(f_max(i))) u_fld (
      .clk(clk), .rst(rst), .hold(hold_q), .adv(adv[i]), .wr_en(cnt_wr[i]),
      .wdata(bus_wdata), .limit(lim[i]), .value(cnt[i]), .wrap(wrap[i]),
      .next_v(next_v[i])
    );
  end

  rtc_alarm_bank u_alarm (
    .clk(clk), .rst(rst), .alm_wr(alm_wr), .wdata(bus_wdata), .en_wr(en_wr),
    .clr(clr_v), .adv(adv), .next_v(next_v), .alarm(alarm), .en(irq_en),
    .flags(flags), .irq(irq)
  );

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NF; i++) begin
      if (bus_addr == 4'(i))         rd_mux = cnt[i];
      if (bus_addr == 4'(A_ALM + i)) rd_mux = alarm[i];
    end
    case (bus_addr)
      A_CTRL:  rd_mux = {hold_q, 1'b0, test_q, 1'b0};
      A_DIV:   rd_mux = 8'(div_q);
      A_EN:    rd_mux = {{(8-NF){1'b0}}, irq_en};
      A_FLAG:  rd_mux = {{(8-NF){1'b0}}, flags};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker import rtc_pkg::*; (
  input logic               clk,
  input logic               rst,
  input logic               hold,
  input logic               tick,
  input logic               irq,
  input logic [NF-1:0]      cnt_wr,
  input logic [NF-1:0]      flags,
  input logic [NF-1:0]      en,
  input logic [NF-1:0]      clr,
  input logic [NF-1:0][7:0] cnt
);
  function automatic logic all_bcd(input logic [NF-1:0][7:0] c);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NF; i++) ok = ok && (c[i][3:0] <= 4'd9) && (c[i][7:4] <= 4'd9);
    return ok;
  endfunction

  function automatic logic [NF-1:0][7:0] min_all();
    logic [NF-1:0][7:0] m;
    for (int i = 0; i < NF; i++) m[i] = f_min(i);
    return m;
  endfunction

  a_r8_bcd_legal: assert property (@(posedge clk) disable iff (rst) all_bcd(cnt));

  a_r3_hold_clears: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == min_all()));

  a_r4_no_step_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && (cnt_wr == '0) && !hold) |=> $stable(cnt));

  // R9 sticky flags, R10 clear only by a written 1
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == '0));

  a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(flags & en))));
endmodule

bind bcd_calendar_rtc rtc_checker u_chk (
  .clk(clk), .rst(rst), .hold(hold_q), .tick(tick), .irq(irq), .cnt_wr(cnt_wr),
  .flags(flags), .en(irq_en), .clr(clr_v), .cnt(cnt)
);

// File: tb/tb_bcd_calendar_rtc.sv
module tb_bcd_calendar_rtc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  always #5 clk = ~clk;

  bcd_calendar_rtc dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    int         due;
    string      tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0, n_chk = 0, n_fail = 0, last_wr = 0, base = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items once their result is visible
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it  = sbq.pop_front();
      act = it.is_irq ? {7'b0, irq} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; last_wr = cyc;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    sbq.push_back('{1'b0, e, cyc + 1, tag});
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    sbq.push_back('{1'b1, {7'b0, e}, cyc, tag});
    @(negedge clk);
  endtask

  // window after n ticks from release (divisor 63: steps at base+2+64n)
  task automatic win(input int n);
    while (cyc < base + 64 * n + 12) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R4: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4'd0, 8'h00, "R1 second reset");
    rd(4'd3, 8'h01, "R1 day reset");
    rd(4'd4, 8'h01, "R1 month reset");
    rd(4'd5, 8'h00, "R1 year reset");
    rd(4'd6, 8'h80, "R1 control reset");
    rd(4'd7, 8'd99, "R1 divisor reset");
    rd(4'd11, 8'h01, "R1 day alarm reset");
    rd(4'd15, 8'h00, "R1 flags reset");
    chk_irq(1'b0, "R1 irq reset");
    // R3 counter writes ignored while held
    wr(4'd0, 8'h30);
    rd(4'd0, 8'h00, "R3 write ignored in hold");
    // R12 reserved bits
    wr(4'd6, 8'hFF);
    rd(4'd6, 8'hBE, "R12 control reserved bits");
    wr(4'd14, 8'hFF);
    rd(4'd14, 8'h3F, "R12 enable reserved bits");
    wr(4'd6, 8'h80);
    // scenario A: full carry, non-leap February, alarms
    wr(4'd7, 8'd63);
    rd(4'd7, 8'd63, "R2 divisor write");
    wr(4'd14, 8'h02);
    wr(4'd6, 8'h00);
    base = last_wr;
    wr(4'd0, 8'h58); wr(4'd1, 8'h59); wr(4'd2, 8'h23);
    wr(4'd3, 8'h28); wr(4'd4, 8'h02); wr(4'd5, 8'h23);
    win(0);
    rd(4'd0, 8'h58, "R2 second written");
    rd(4'd2, 8'h23, "R2 hour written");
    win(1);
    rd(4'd0, 8'h59, "R4 one tick second");
    rd(4'd1, 8'h59, "R4 minute waits for carry");
    rd(4'd15, 8'h00, "R9 no early flag");
    win(2);
    rd(4'd0, 8'h00, "R5 second wrap");
    rd(4'd1, 8'h00, "R5 minute wrap");
    rd(4'd2, 8'h00, "R5 hour wrap");
    rd(4'd3, 8'h01, "R6 Feb non-leap day wrap");
    rd(4'd4, 8'h03, "R6 month carry");
    rd(4'd5, 8'h23, "R4 year unchanged");
    rd(4'd15, 8'h0F, "R9 flags on match");
    chk_irq(1'b1, "R11 irq enabled flag");
    wr(4'd15, 8'h00);
    rd(4'd15, 8'h0F, "R10 zero clear no effect");
    wr(4'd15, 8'h02);
    rd(4'd15, 8'h0D, "R10 clear minute flag");
    chk_irq(1'b0, "R11 irq gated by enable");
    wr(4'd15, 8'hFD);
    rd(4'd15, 8'h00, "R10 clear rest");
    // scenario B: clamp, leap year, test mode
    wr(4'd6, 8'h80);
    wr(4'd14, 8'h00);
    rd(4'd0, 8'h00, "R3 hold resets second");
    rd(4'd4, 8'h01, "R3 hold resets month");
    wr(4'd6, 8'h00);
    base = last_wr;
    wr(4'd0, 8'h5A); wr(4'd1, 8'h45); wr(4'd2, 8'h24);
    wr(4'd3, 8'h00); wr(4'd4, 8'h13);
    win(0);
    rd(4'd0, 8'h00, "R8 clamp bad nibble");
    rd(4'd1, 8'h45, "R8 legal kept");
    rd(4'd2, 8'h00, "R8 clamp hour");
    rd(4'd3, 8'h01, "R8 clamp day zero");
    rd(4'd4, 8'h01, "R8 clamp month");
    wr(4'd0, 8'h59); wr(4'd1, 8'h59); wr(4'd2, 8'h23);
    wr(4'd3, 8'h28); wr(4'd4, 8'h02); wr(4'd5, 8'h24);
    wr(4'd6, 8'h20);
    win(1);
    rd(4'd2, 8'h00, "R5 hour wrap again");
    rd(4'd3, 8'h29, "R6 leap February day 29");
    rd(4'd4, 8'h02, "R6 no month carry");
    rd(4'd5, 8'h25, "R7 year test step");
    chk_irq(1'b0, "R11 no irq when disabled");
    wr(4'd5, 8'h99); wr(4'd4, 8'h12); wr(4'd6, 8'h30);
    win(2);
    rd(4'd0, 8'h01, "R4 second step");
    rd(4'd3, 8'h29, "R7 day not in test");
    rd(4'd4, 8'h01, "R5 month wrap");
    rd(4'd5, 8'h00, "R5 year wrap");
    win(3);
    rd(4'd1, 8'h00, "R7 minute not in test");
    rd(4'd4, 8'h02, "R7 month test step");
    rd(4'd5, 8'h01, "R7 year test step");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule